// File: doc/BRIEF.md
# Fine-Grained Instruction Trap Decision Unit

This unit decides, for each instruction presented to it, whether execution must be diverted to the hypervisor level. It works from a 2-bit word of trap enables. Bit 1 is an active-low enable for cache clean/invalidate-to-physical-storage maintenance instructions. Bit 0 is an active-high enable for the trace-synchronisation barrier. The decision also uses the current exception level, whether the hypervisor level is present and enabled in the current security state, the effective host-mode flag pair, a feature-present flag for each enable bit, and whether the instruction already raises a higher-priority exception.

The decision is registered. One clock after a valid instruction is offered, the unit raises a trap strobe and an 8-bit syndrome class code. The code is 0x18 for a maintenance trap and 0x0A for a barrier trap. The surrounding pipeline uses the strobe to start exception entry. Instruction decode and the maintenance operation itself lie outside the unit.

Top module: `fgt_trap_unit`

## Requirements
- R1: While `rst_n` is low, at the first clock edge `trap_o` and `syn_class_o` are cleared to zero, whatever the other inputs are.
- R2: The outputs reflect the inputs sampled at the previous rising edge. With `in_valid` low at that edge, `trap_o` is 0.
- R3: A maintenance instruction (`insn_class` = 2'b01) traps if all of the following hold: it is at EL1 (`cur_el` = 2'd1), `hyp_en` is 1 and control bit 1 is 0. It then reports syndrome 0x18.
- R4: With control bit 1 set to 1 and its feature present, a maintenance instruction does not trap.
- R5: A barrier instruction (`insn_class` = 2'b10) traps if all of the following hold: it is at EL0 or EL1, `hyp_en` is 1, control bit 0 is 1 and the host pair is not {1,1}. It then reports syndrome 0x0A. With control bit 0 at 0 it does not trap.
- R6: A barrier instruction does not trap when `host_e2h` and `host_tge` are both 1. Any other host pair does not block it, and the host pair has no effect on maintenance traps.
- R7: Each control bit is taken as 0 when its feature flag is low: `feat_cmo` for bit 1 and `feat_tsb` for bit 0. With `feat_cmo` low, a maintenance instruction that meets R3's other conditions traps. With `feat_tsb` low, a barrier instruction never traps.
- R8: When `hi_pri_exc` is 1, no trap is reported.
- R9: No trap occurs at EL2 or EL3. A maintenance instruction at EL0 does not trap either.
- R10: Class 2'b00 never traps, and nothing traps while `hyp_en` is 0.
- R11: Whenever `trap_o` is 0, `syn_class_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction inputs are valid this cycle |
| ctl_bits | input | 2 | Trap enables: bit 1 maintenance (active low), bit 0 barrier (active high) |
| cur_el | input | 2 | Exception level of the instruction |
| hyp_en | input | 1 | Hypervisor level implemented and enabled in current security state |
| host_e2h | input | 1 | Effective host-mode flag E2H |
| host_tge | input | 1 | Effective host-mode flag TGE |
| feat_cmo | input | 1 | Maintenance trap feature present |
| feat_tsb | input | 1 | Barrier trap feature present |
| insn_class | input | 2 | 01 maintenance, 10 barrier, 00 other |
| hi_pri_exc | input | 1 | Instruction raises a higher-priority exception |
| trap_o | output | 1 | Trap taken |
| syn_class_o | output | 8 | Syndrome class of the trap, 0 when none |

## Verification
A wrong stored decision shows at the ports in the cycle right after the valid instruction. The decision register feeds the outputs directly, so a stale or flipped bit appears either as a trap strobe with the wrong syndrome or as a syndrome left non-zero with no strobe. The polarity and qualifier errors that matter most are a swapped active-low enable, a missing host-pair exclusion and an ignored priority flag. Each of these changes the outcome of at least one single-cycle vector.

// File: rtl/fgt_trap_unit.sv
module fgt_trap_unit #(
  parameter logic [7:0] SYN_CMO = 8'h18,
  parameter logic [7:0] SYN_TSB = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] ctl_bits,
  input  logic [1:0] cur_el,
  input  logic       hyp_en,
  input  logic       host_e2h,
  input  logic       host_tge,
  input  logic       feat_cmo,
  input  logic       feat_tsb,
  input  logic [1:0] insn_class,
  input  logic       hi_pri_exc,
  output logic       trap_o,
  output logic [7:0] syn_class_o
);
  localparam logic [1:0] CLS_CMO = 2'b01;
  localparam logic [1:0] CLS_TSB = 2'b10;

  logic eff_ncmo, eff_tsb, hit_cmo, hit_tsb, hit;

  assign eff_ncmo = feat_cmo & ctl_bits[1];
  assign eff_tsb  = feat_tsb & ctl_bits[0];

  assign hit_cmo = (insn_class == CLS_CMO) && (cur_el == 2'd1) && !eff_ncmo;
  assign hit_tsb = (insn_class == CLS_TSB) && (cur_el <= 2'd1) && eff_tsb
                   && !(host_e2h && host_tge);
  assign hit = in_valid && hyp_en && !hi_pri_exc && (hit_cmo || hit_tsb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_o      <= 1'b0;
      syn_class_o <= 8'h00;
    end else begin
      trap_o      <= hit;
      syn_class_o <= !hit ? 8'h00 : (hit_cmo ? SYN_CMO : SYN_TSB);
    end
  end
endmodule

module fgt_trap_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] cur_el,
  input logic       hyp_en,
  input logic       host_e2h,
  input logic       host_tge,
  input logic [1:0] insn_class,
  input logic       hi_pri_exc,
  input logic       trap_o,
  input logic [7:0] syn_class_o
);
  a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(in_valid));
  a_r8_priority_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !$past(hi_pri_exc));
  a_r9_low_level_only: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(cur_el) <= 2'd1));
  a_r10_hyp_and_class: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(hyp_en) && $past(insn_class) != 2'b00));
  a_r11_quiet_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> (syn_class_o == 8'h00));
  a_r3_cmo_code: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && $past(insn_class) == 2'b01) |-> (syn_class_o == 8'h18));
  a_r6_host_block: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && $past(insn_class) == 2'b10) |->
      (!($past(host_e2h) && $past(host_tge)) && syn_class_o == 8'h0A));
endmodule

bind fgt_trap_unit fgt_trap_unit_chk chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_el(cur_el),
  .hyp_en(hyp_en), .host_e2h(host_e2h), .host_tge(host_tge),
  .insn_class(insn_class), .hi_pri_exc(hi_pri_exc),
  .trap_o(trap_o), .syn_class_o(syn_class_o)
);

// File: tb/fgt_trap_unit_test.sv
`timescale 1ns/1ps
module fgt_trap_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] ctl_bits = 2'b00, cur_el = 2'd0, insn_class = 2'b00;
  logic hyp_en = 1'b0, host_e2h = 1'b0, host_tge = 1'b0;
  logic feat_cmo = 1'b1, feat_tsb = 1'b1, hi_pri_exc = 1'b0;
  logic trap_o;
  logic [7:0] syn_class_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fgt_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctl_bits(ctl_bits),
    .cur_el(cur_el), .hyp_en(hyp_en), .host_e2h(host_e2h), .host_tge(host_tge),
    .feat_cmo(feat_cmo), .feat_tsb(feat_tsb), .insn_class(insn_class),
    .hi_pri_exc(hi_pri_exc), .trap_o(trap_o), .syn_class_o(syn_class_o)
  );

  // {req, ctl, el, hyp, e2h, tge, fc, ft, cls, hp, exp_trap, exp_syn}
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {8'd3,  2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 8'h18}, // R3
    {8'd4,  2'b10, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00}, // R4
    {8'd5,  2'b01, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h0A}, // R5
    {8'd5,  2'b01, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h0A}, // R5
    {8'd5,  2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00}, // R5
    {8'd6,  2'b01, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00}, // R6
    {8'd6,  2'b01, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h0A}, // R6
    {8'd6,  2'b01, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h0A}, // R6
    {8'd6,  2'b00, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 8'h18}, // R6
    {8'd7,  2'b10, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 8'h18}, // R7
    {8'd7,  2'b01, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 8'h00}, // R7
    {8'd8,  2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 8'h00}, // R8
    {8'd8,  2'b01, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 8'h00}, // R8
    {8'd9,  2'b00, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00}, // R9
    {8'd9,  2'b01, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00}, // R9
    {8'd9,  2'b00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00}, // R9
    {8'd10, 2'b00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00}  // R10
  };

  task automatic check(input int req, input logic et, input logic [7:0] es);
    checks++;
    if (trap_o !== et || syn_class_o !== es) begin
      failures++;
      $display("FAIL R%0d: trap=%0b syn=%02h expected trap=%0b syn=%02h",
               req, trap_o, syn_class_o, et, es);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with trap-causing inputs
    in_valid = 1'b1; hyp_en = 1'b1; cur_el = 2'd1; insn_class = 2'b01; ctl_bits = 2'b00;
    @(posedge clk); @(negedge clk);
    check(1, 1'b0, 8'h00);
    @(negedge clk);
    check(1, 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(3, 1'b1, 8'h18);

    for (int i = 0; i < NV; i++) begin
      {ctl_bits, cur_el, hyp_en, host_e2h, host_tge, feat_cmo, feat_tsb,
       insn_class, hi_pri_exc} = VEC[i][20:9];
      in_valid = 1'b1;
      @(negedge clk);
      check(int'(VEC[i][28:21]), VEC[i][8], VEC[i][7:0]); // R11 via zero codes
    end

    // R10: class 00 never traps
    feat_cmo = 1'b1; feat_tsb = 1'b1; hyp_en = 1'b1; cur_el = 2'd1;
    host_e2h = 1'b0; host_tge = 1'b0; hi_pri_exc = 1'b0;
    ctl_bits = 2'b01; insn_class = 2'b00;
    @(negedge clk);
    check(10, 1'b0, 8'h00);

    // R2: invalid input, then valid, then invalid again
    insn_class = 2'b10; in_valid = 1'b0;
    @(negedge clk);
    check(2, 1'b0, 8'h00);
    in_valid = 1'b1;
    @(negedge clk);
    check(2, 1'b1, 8'h0A);
    in_valid = 1'b0;
    @(negedge clk);
    check(2, 1'b0, 8'h00);

    // R11: back-to-back trap then no trap clears syndrome
    in_valid = 1'b1; insn_class = 2'b01; ctl_bits = 2'b00;
    @(negedge clk);
    check(3, 1'b1, 8'h18);
    ctl_bits = 2'b10;
    @(negedge clk);
    check(11, 1'b0, 8'h00);

    // R1: reset mid-run clears a pending trap
    ctl_bits = 2'b00;
    @(negedge clk);
    check(3, 1'b1, 8'h18);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule